// File: doc/BRIEF.md
# Register-Based Page Translation Unit

This block turns a logical word address into a physical word address through a small page table kept entirely in flip-flops. The low bits of the logical address are the offset inside a page and pass through unchanged; the high bits select one table entry, whose frame number replaces them. Each entry also holds a presence flag and a write-permission flag. A separate length register bounds which page numbers the table covers.

A request is presented for one cycle with its access kind (read or write). Exactly one cycle later the unit returns either the physical address or a fault with a two-bit cause. A configuration port loads table entries and the length register. It acts only while the privileged qualifier is high. After reset, no entry is present and the length is zero, so every access faults until software has set up the table.

Top module: `page_xlate_unit`

## Requirements
- R1: A translated response carries the physical address `{frame, offset}`: the entry's frame number as the high bits, and the request's low OFFSET_W bits unchanged as the low bits.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A page number greater than or equal to the length register gives a fault with cause 2'b01, and `rsp_paddr` is zero in every faulting response.
- R4: A page number that is in bounds and refers to an entry whose present flag is clear gives a fault with cause 2'b10.
- R5: A write (`req_write` = 1) to a present, in-bounds entry whose write-permission flag is 0 gives a fault with cause 2'b11. A read of such a page translates normally.
- R6: When several causes apply, the out-of-bounds cause wins over the not-present cause, and the not-present cause wins over the protection cause.
- R7: Entry and length writes with `cfg_priv` low leave the table and the length unchanged.
- R8: After reset, all present flags are clear and the length is zero, so any access faults with cause 2'b01.
- R9: With 4-word pages, page 0 mapped to frame 5, page 1 to frame 6 and page 3 to frame 2, logical addresses 0, 3, 4 and 13 translate to 20, 23, 24 and 9.
- R10: A response without a fault has `rsp_fault` low and `rsp_cause` equal to 2'b00. `rsp_fault` is high exactly when `rsp_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Access kind: 1 write, 0 read |
| req_laddr | input | PAGE_W+OFFSET_W | Logical word address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | FRAME_W+OFFSET_W | Physical word address, zero on fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 2 | 00 none, 01 bounds, 10 not present, 11 protection |
| cfg_priv | input | 1 | Privilege qualifier for configuration writes |
| cfg_entry_we | input | 1 | Write one table entry |
| cfg_entry_idx | input | PAGE_W | Entry index to write |
| cfg_frame | input | FRAME_W | Frame number to store |
| cfg_present | input | 1 | Present flag to store |
| cfg_writable | input | 1 | Write-permission flag to store |
| cfg_len_we | input | 1 | Write the length register |
| cfg_len | input | PAGE_W+1 | New table length (0 to 2^PAGE_W) |

## Verification
The bench uses the defaults: OFFSET_W=2, PAGE_W=3 and FRAME_W=3. That gives 4-word pages, eight entries and eight frames, so the worked mapping of R9 applies directly. Every entry index can be reached, and a length of 6 leaves pages 6 and 7 out of bounds. With eight entries, each combination of present and writable flags fits in the table alongside the bounds case. The table therefore exercises every cause and every priority pairing of R6.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_BOUNDS  = 2'b01,
    CAUSE_ABSENT  = 2'b10,
    CAUSE_PROTECT = 2'b11
  } pgx_cause_e;

  // Priority: bounds over absent over protection.
  function automatic pgx_cause_e pick_cause(input logic oob, input logic absent,
                                            input logic prot);
    if (oob)         return CAUSE_BOUNDS;
    else if (absent) return CAUSE_ABSENT;
    else if (prot)   return CAUSE_PROTECT;
    else             return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PAGE_W  = 3,
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv,
  input  logic               entry_we,
  input  logic [PAGE_W-1:0]  entry_idx,
  input  logic [FRAME_W-1:0] entry_frame,
  input  logic               entry_present,
  input  logic               entry_writable,
  input  logic               len_we,
  input  logic [PAGE_W:0]    len_in,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_present,
  output logic               rd_writable,
  output logic [PAGE_W:0]    len_q
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [FRAME_W-1:0] frame_q    [ENTRIES];
  logic               present_q  [ENTRIES];
  logic               writable_q [ENTRIES];

  logic entry_wr_ok;
  logic len_wr_ok;
  assign entry_wr_ok = priv && entry_we;
  assign len_wr_ok   = priv && len_we;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q[e]    <= '0;
        present_q[e]  <= 1'b0;
        writable_q[e] <= 1'b0;
      end else if (entry_wr_ok && (entry_idx == PAGE_W'(e))) begin
        frame_q[e]    <= entry_frame;
        present_q[e]  <= entry_present;
        writable_q[e] <= entry_writable;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (len_wr_ok) len_q <= len_in;
  end

  assign rd_frame    = frame_q[rd_page];
  assign rd_present  = present_q[rd_page];
  assign rd_writable = writable_q[rd_page];
endmodule

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W:0]   len,
  input  logic              present,
  input  logic              writable,
  input  logic              is_write,
  output logic              oob,
  output logic              absent,
  output logic              prot,
  output pgx_cause_e        cause
);
  function automatic logic beyond_len(input logic [PAGE_W-1:0] p,
                                      input logic [PAGE_W:0] l);
    return ({1'b0, p} >= l);
  endfunction

  assign oob    = beyond_len(page, len);
  assign absent = !present;
  assign prot   = is_write && !writable;
  assign cause  = pick_cause(oob, absent, prot);
endmodule

// File: rtl/pgx_resp.sv
module pgx_resp
  import pgx_pkg::*;
#(
  parameter int PA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  pgx_cause_e      cause,
  input  logic [PA_W-1:0] paddr,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [1:0]      rsp_cause,
  output logic [PA_W-1:0] rsp_paddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'b00;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_fault <= (cause != CAUSE_NONE);
        rsp_cause <= cause;
        rsp_paddr <= (cause == CAUSE_NONE) ? paddr : '0;
      end
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pgx_pkg::*;
#(
  parameter int OFFSET_W = 2,
  parameter int PAGE_W   = 3,
  parameter int FRAME_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [PAGE_W+OFFSET_W-1:0]  req_laddr,
  output logic                        rsp_valid,
  output logic [FRAME_W+OFFSET_W-1:0] rsp_paddr,
  output logic                        rsp_fault,
  output logic [1:0]                  rsp_cause,
  input  logic                        cfg_priv,
  input  logic                        cfg_entry_we,
  input  logic [PAGE_W-1:0]           cfg_entry_idx,
  input  logic [FRAME_W-1:0]          cfg_frame,
  input  logic                        cfg_present,
  input  logic                        cfg_writable,
  input  logic                        cfg_len_we,
  input  logic [PAGE_W:0]             cfg_len
);
  localparam int LA_W = PAGE_W + OFFSET_W;
  localparam int PA_W = FRAME_W + OFFSET_W;

  function automatic logic [PA_W-1:0] join_addr(input logic [FRAME_W-1:0] f,
                                                input logic [OFFSET_W-1:0] o);
    return {f, o};
  endfunction

  logic [PAGE_W-1:0]   page_w;
  logic [OFFSET_W-1:0] offset_w;
  logic [FRAME_W-1:0]  frame_w;
  logic                present_w;
  logic                writable_w;
  logic [PAGE_W:0]     len_q;
  logic                oob_w;
  logic                absent_w;
  logic                prot_w;
  pgx_cause_e          cause_w;
  logic [PA_W-1:0]     paddr_w;

  assign page_w   = req_laddr[LA_W-1:OFFSET_W];
  assign offset_w = req_laddr[OFFSET_W-1:0];

  pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .priv           (cfg_priv),
    .entry_we       (cfg_entry_we),
    .entry_idx      (cfg_entry_idx),
    .entry_frame    (cfg_frame),
    .entry_present  (cfg_present),
    .entry_writable (cfg_writable),
    .len_we         (cfg_len_we),
    .len_in         (cfg_len),
    .rd_page        (page_w),
    .rd_frame       (frame_w),
    .rd_present     (present_w),
    .rd_writable    (writable_w),
    .len_q          (len_q)
  );

  pgx_check #(.PAGE_W(PAGE_W)) u_check (
    .page     (page_w),
    .len      (len_q),
    .present  (present_w),
    .writable (writable_w),
    .is_write (req_write),
    .oob      (oob_w),
    .absent   (absent_w),
    .prot     (prot_w),
    .cause    (cause_w)
  );

  assign paddr_w = join_addr(frame_w, offset_w);

  pgx_resp #(.PA_W(PA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (req_valid),
    .cause     (cause_w),
    .paddr     (paddr_w),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr)
  );
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
  parameter int OFFSET_W = 2,
  parameter int PAGE_W   = 3,
  parameter int FRAME_W  = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [PAGE_W+OFFSET_W-1:0]  req_laddr,
  input logic                        rsp_valid,
  input logic                        rsp_fault,
  input logic [1:0]                  rsp_cause,
  input logic [FRAME_W+OFFSET_W-1:0] rsp_paddr,
  input logic                        cfg_priv,
  input logic [PAGE_W:0]             len_q,
  input logic                        oob_w,
  input logic                        absent_w
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault || rsp_paddr[OFFSET_W-1:0] == $past(req_laddr[OFFSET_W-1:0]))); // R1
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3
  AST_BOUNDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && oob_w) |=> (rsp_cause == 2'b01)); // R3
  AST_ABSENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !oob_w && absent_w) |=> (rsp_cause == 2'b10)); // R6
  AST_FAULT_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00))); // R10
  AST_UNPRIV_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_priv |=> $stable(len_q)); // R7
endmodule

bind page_xlate_unit pgx_checker #(
  .OFFSET_W (OFFSET_W),
  .PAGE_W   (PAGE_W),
  .FRAME_W  (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_laddr (req_laddr),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .rsp_paddr (rsp_paddr),
  .cfg_priv  (cfg_priv),
  .len_q     (len_q),
  .oob_w     (oob_w),
  .absent_w  (absent_w)
);

// File: tb/sim_page_xlate_unit.sv
module sim_page_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OFFSET_W = 2;
  localparam int PAGE_W   = 3;
  localparam int FRAME_W  = 3;
  localparam int LA_W = PAGE_W + OFFSET_W;
  localparam int PA_W = FRAME_W + OFFSET_W;
  localparam int NVEC = 14;

  // {write, laddr[4:0], cause[1:0], paddr[4:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  2'b00, 5'd20}, // R9 page0 off0
    {1'b0, 5'd3,  2'b00, 5'd23}, // R9 page0 off3
    {1'b1, 5'd4,  2'b00, 5'd24}, // R9 page1 off0, write ok
    {1'b0, 5'd13, 2'b00, 5'd9},  // R9 page3 off1
    {1'b1, 5'd7,  2'b00, 5'd27}, // R1 page1 off3
    {1'b0, 5'd9,  2'b00, 5'd5},  // R5 read of read-only page2
    {1'b1, 5'd9,  2'b11, 5'd0},  // R5 write of read-only page2
    {1'b0, 5'd16, 2'b10, 5'd0},  // R4 absent page4
    {1'b1, 5'd18, 2'b10, 5'd0},  // R6 absent beats protection
    {1'b0, 5'd22, 2'b00, 5'd30}, // R1 page5 off2 -> frame7
    {1'b1, 5'd22, 2'b11, 5'd0},  // R5 write of read-only page5
    {1'b0, 5'd24, 2'b01, 5'd0},  // R3 page6 present but out of bounds
    {1'b1, 5'd31, 2'b01, 5'd0},  // R6 bounds beats absent and protection
    {1'b0, 5'd1,  2'b00, 5'd21}  // R10 clean response
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LA_W-1:0] req_laddr = '0;
  logic rsp_valid, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_cause;
  logic cfg_priv = 1'b0, cfg_entry_we = 1'b0, cfg_present = 1'b0, cfg_writable = 1'b0;
  logic cfg_len_we = 1'b0;
  logic [PAGE_W-1:0] cfg_entry_idx = '0;
  logic [FRAME_W-1:0] cfg_frame = '0;
  logic [PAGE_W:0] cfg_len = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_unit #(.OFFSET_W(OFFSET_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .cfg_priv(cfg_priv),
    .cfg_entry_we(cfg_entry_we), .cfg_entry_idx(cfg_entry_idx), .cfg_frame(cfg_frame),
    .cfg_present(cfg_present), .cfg_writable(cfg_writable), .cfg_len_we(cfg_len_we),
    .cfg_len(cfg_len)
  );

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'b00: return "R1";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [PA_W-1:0] expect_pa(input int frame, input int laddr);
    return PA_W'(frame * (1 << OFFSET_W) + (laddr % (1 << OFFSET_W)));
  endfunction

  task automatic check_resp(input string tag, input logic [1:0] ecause,
                            input logic [PA_W-1:0] epa);
    logic efault;
    efault = (ecause != 2'b00);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_cause !== ecause || rsp_fault !== efault ||
        rsp_paddr !== epa) begin
      fails++;
      $display("FAIL %s: valid=%0b cause=%0b fault=%0b paddr=%0d, expected valid=1 cause=%0b fault=%0b paddr=%0d",
               tag, rsp_valid, rsp_cause, rsp_fault, rsp_paddr, ecause, efault, epa);
    end
  endtask

  task automatic access(input logic w, input logic [LA_W-1:0] la, input string tag,
                        input logic [1:0] ecause, input logic [PA_W-1:0] epa);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    check_resp(tag, ecause, epa);
  endtask

  task automatic set_entry(input logic priv, input int idx, input int frame,
                           input logic pres, input logic wr);
    @(negedge clk);
    cfg_priv = priv; cfg_entry_we = 1'b1; cfg_entry_idx = PAGE_W'(idx);
    cfg_frame = FRAME_W'(frame); cfg_present = pres; cfg_writable = wr;
    @(negedge clk);
    cfg_entry_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic set_len(input logic priv, input int len);
    @(negedge clk);
    cfg_priv = priv; cfg_len_we = 1'b1; cfg_len = (PAGE_W+1)'(len);
    @(negedge clk);
    cfg_len_we = 1'b0; cfg_priv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R8: rsp_valid=%0b expected 0 in reset", rsp_valid);
    end
    rst_n = 1'b1;
    access(1'b0, 5'd0, "R8", 2'b01, '0);
    access(1'b1, 5'd31, "R8", 2'b01, '0);
    // R2: idle gives no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R2: rsp_valid=%0b expected 0 when idle", rsp_valid);
    end
    // Program table
    set_entry(1'b1, 0, 5, 1'b1, 1'b1);
    set_entry(1'b1, 1, 6, 1'b1, 1'b1);
    set_entry(1'b1, 2, 1, 1'b1, 1'b0);
    set_entry(1'b1, 3, 2, 1'b1, 1'b1);
    set_entry(1'b1, 4, 3, 1'b0, 1'b0);
    set_entry(1'b1, 5, 7, 1'b1, 1'b0);
    set_entry(1'b1, 6, 0, 1'b1, 1'b1);
    set_entry(1'b1, 7, 4, 1'b0, 1'b0);
    set_len(1'b1, 6);
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][12], VEC[i][11:7], tag_of(VEC[i][6:5]), VEC[i][6:5], VEC[i][4:0]);
    end
    // R7: unprivileged writes ignored
    set_entry(1'b0, 4, 1, 1'b1, 1'b1);
    set_len(1'b0, 8);
    access(1'b0, 5'd16, "R7", 2'b10, '0);
    access(1'b0, 5'd24, "R7", 2'b01, '0);
    // R2: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_laddr = 5'd2;
    @(negedge clk);
    check_resp("R2", 2'b00, expect_pa(5, 2));
    req_laddr = 5'd14;
    @(negedge clk);
    req_valid = 1'b0;
    check_resp("R2", 2'b00, expect_pa(2, 14));
    // R1: privileged remap takes effect
    set_entry(1'b1, 0, 3, 1'b1, 1'b1);
    access(1'b0, 5'd1, "R1", 2'b00, expect_pa(3, 1));
    // R3: zero length blocks every page
    set_len(1'b1, 0);
    access(1'b0, 5'd0, "R3", 2'b01, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule